// File: doc/BRIEF.md
# Write-Update Snooping Cache Controller

This controller runs a small direct-mapped, write-through data cache for one processor on a shared memory bus. The processor side issues single-word reads and writes and waits for a one-cycle ready pulse. The bus side makes requests, waits for a grant, and then waits for a completion strobe from memory. The same bus side also watches the writes that other agents put on the bus.

The coherence policy is update-based. Every processor write goes onto the bus as a write transaction, whether it hits or misses. When another agent's write matches a valid local line, this controller overwrites its copy of that word with the broadcast data and keeps the line valid. Memory is always current, so a read miss goes straight to memory and needs no reply from other caches. A read hit is answered locally.

The tag and valid store has two lookup ports, one for the processor and one for snooping, so a snooped write never holds up a processor access. The data store has two ports. The snoop port only writes. The processor port reads, writes and fills. When both ports write the same entry in the same cycle, the processor's data is the value that remains.

Top module: `wu_snoop_cache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address is a miss and issues a bus read. `cpu_ready` and `bus_req` are low while reset is applied and just after it.
- R2: Every processor write, hit or miss, raises `bus_req` with `bus_we`=1. `bus_addr` and `bus_wdata` carry the processor's address and data.
- R3: A processor write that misses does not allocate. A later read of that address is still a miss.
- R4: A processor write that hits updates the local word in the cycle its bus write completes. A following read hits and returns the new data with no bus traffic.
- R5: A read miss issues one bus read (`bus_we`=0). It fills the line with `bus_rdata` and returns that data. `cpu_ready` rises one cycle after the cycle in which `bus_done` is accepted.
- R6: A read hit raises `cpu_ready` one cycle after the request and does not raise `bus_req`.
- R7: A snooped write (`snoop_valid`) whose address matches a valid local line replaces that word with `snoop_wdata`. The line stays valid, so a later read hits and returns the snooped data.
- R8: A snooped write that misses is ignored. It allocates no line and leaves a different resident tag at the same index untouched.
- R9: Snooping does not stall the processor. A read hit issued in the same cycle as a snooped write to another line still completes in one cycle, and both effects are kept.
- R10: If a snoop update and a processor write (or fill) hit the same data entry in one cycle, the processor's data is what remains. If they hit different entries, both are applied.
- R11: A bus transaction does not start before `bus_gnt`. `bus_req` stays high and `cpu_ready` stays low for as long as the grant is withheld. Only after the grant is `bus_done` accepted.
- R12: The cache is direct-mapped: index = low `IDX_W` address bits, tag = the remaining bits. A read miss replaces whatever line sat at that index, so the earlier address then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request pulse, accepted while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_ready` is high |
| bus_req | output | 1 | Bus request, held until the transaction completes |
| bus_gnt | input | 1 | Bus grant |
| bus_we | output | 1 | Transaction direction, 1 = write |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Transaction write data |
| bus_done | input | 1 | Memory completion strobe |
| bus_rdata | input | DATA_W | Memory read data, valid with `bus_done` |
| snoop_valid | input | 1 | Another agent's bus write is present |
| snoop_addr | input | ADDR_W | Snooped write address |
| snoop_wdata | input | DATA_W | Snooped write data |

## Verification
The bench builds the block with `ADDR_W`=8, `IDX_W`=2 and `DATA_W`=16. With only four lines, addresses such as 0x10 and 0x30 share an index, so replacement on a fill and snoops that miss on a different resident tag can be reached in a few accesses. The 256-word address space lets the bench keep a full memory model. That model has a settable grant delay, which exercises the wait-for-grant path. It can also inject a snooped write in the exact cycle the processor's write completes, which drives both data ports at once, on the same entry and on different entries.

// File: rtl/wu_cache_pkg.sv
package wu_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } wu_state_e;

endpackage

// File: rtl/wu_tag_array.sv
module wu_tag_array #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic [TAG_W-1:0] cpu_tag,
  output logic             cpu_hit,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [TAG_W-1:0] snp_tag,
  output logic             snp_hit,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  // valid bits: cleared by reset, set only by a read-miss fill
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (fill_en) begin
      valid_q[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx] <= fill_tag;
    end
  end

  // two independent lookup ports
  always_comb begin
    cpu_hit = valid_q[cpu_idx] && (tag_q[cpu_idx] == cpu_tag);
    snp_hit = valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);
  end

  AST_RESET_CLEARS_VALID: assert property (@(posedge clk)
    rst |=> (valid_q == '0)); // R1

  AST_FILL_MAKES_VALID: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> valid_q[$past(fill_idx)]); // R5

endmodule

// File: rtl/wu_data_ram.sv
module wu_data_ram #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_we,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_we,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [DATA_W-1:0] b_data,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] mem [LINES];

  // port A: snoop, write only. port B: processor, read-first with write.
  // B is written after A, so B wins on a shared entry.
  always_ff @(posedge clk) begin
    if (a_we) begin
      mem[a_idx] <= a_data;
    end
    if (b_we) begin
      mem[b_idx] <= b_data;
    end
    b_rdata <= mem[b_idx];
  end

  AST_SNOOP_LANDS: assert property (@(posedge clk) disable iff (rst)
    (a_we && !(b_we && (b_idx == a_idx))) |=> (mem[$past(a_idx)] == $past(a_data))); // R7

  AST_PROC_WINS_SAME_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (a_we && b_we && (a_idx == b_idx)) |=> (mem[$past(b_idx)] == $past(b_data))); // R10

endmodule

// File: rtl/wu_snoop_cache.sv
module wu_snoop_cache
  import wu_cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic [DATA_W-1:0] snoop_wdata
);
  localparam int TAG_W = ADDR_W - IDX_W;

  wu_state_e         state_q;
  logic              bus_req_q;
  logic              op_we_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_wdata_q;
  logic              ready_q;
  logic              use_fill_q;
  logic [DATA_W-1:0] fill_q;

  logic [ADDR_W-1:0] lk_addr;
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic [IDX_W-1:0]  snp_idx;
  logic [TAG_W-1:0]  snp_tag;
  logic              cpu_hit;
  logic              snp_hit;
  logic              xfer_done;
  logic              fill_en;
  logic              ram_a_we;
  logic              ram_b_we;
  logic [DATA_W-1:0] ram_b_data;
  logic [DATA_W-1:0] ram_rdata;

  // processor lookup follows the incoming request while idle,
  // the held operation otherwise
  always_comb begin
    lk_addr    = (state_q == ST_IDLE) ? cpu_addr : op_addr_q;
    lk_idx     = lk_addr[IDX_W-1:0];
    lk_tag     = lk_addr[ADDR_W-1:IDX_W];
    snp_idx    = snoop_addr[IDX_W-1:0];
    snp_tag    = snoop_addr[ADDR_W-1:IDX_W];
    xfer_done  = (state_q == ST_XFER) && bus_done;
    fill_en    = xfer_done && !op_we_q;
    ram_a_we   = snoop_valid && snp_hit;
    ram_b_we   = xfer_done && (!op_we_q || cpu_hit);
    ram_b_data = op_we_q ? op_wdata_q : bus_rdata;
  end

  wu_tag_array #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk      (clk),
    .rst      (rst),
    .cpu_idx  (lk_idx),
    .cpu_tag  (lk_tag),
    .cpu_hit  (cpu_hit),
    .snp_idx  (snp_idx),
    .snp_tag  (snp_tag),
    .snp_hit  (snp_hit),
    .fill_en  (fill_en),
    .fill_idx (op_addr_q[IDX_W-1:0]),
    .fill_tag (op_addr_q[ADDR_W-1:IDX_W])
  );

  wu_data_ram #(
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_data (
    .clk     (clk),
    .rst     (rst),
    .a_we    (ram_a_we),
    .a_idx   (snp_idx),
    .a_data  (snoop_wdata),
    .b_we    (ram_b_we),
    .b_idx   (lk_idx),
    .b_data  (ram_b_data),
    .b_rdata (ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      bus_req_q  <= 1'b0;
      op_we_q    <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      ready_q    <= 1'b0;
      use_fill_q <= 1'b0;
      fill_q     <= '0;
    end else begin
      ready_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_req) begin
            if (!cpu_we && cpu_hit) begin
              ready_q    <= 1'b1;
              use_fill_q <= 1'b0;
            end else begin
              state_q    <= ST_REQ;
              bus_req_q  <= 1'b1;
              op_we_q    <= cpu_we;
              op_addr_q  <= cpu_addr;
              op_wdata_q <= cpu_wdata;
            end
          end
        end
        ST_REQ: begin
          if (bus_gnt) begin
            state_q <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (bus_done) begin
            state_q   <= ST_IDLE;
            bus_req_q <= 1'b0;
            ready_q   <= 1'b1;
            if (!op_we_q) begin
              fill_q     <= bus_rdata;
              use_fill_q <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready = ready_q;
  assign cpu_rdata = use_fill_q ? fill_q : ram_rdata;
  assign bus_req   = bus_req_q;
  assign bus_we    = op_we_q;
  assign bus_addr  = op_addr_q;
  assign bus_wdata = op_wdata_q;

  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && cpu_req && !cpu_we && cpu_hit) |=> (cpu_ready && !bus_req)); // R6

  AST_WRITE_BROADCAST: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && cpu_req && cpu_we) |=>
      (bus_req && bus_we && bus_addr == $past(cpu_addr) && bus_wdata == $past(cpu_wdata))); // R2

  AST_WAIT_FOR_GRANT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REQ && !bus_gnt) |=> (state_q == ST_REQ && bus_req && !cpu_ready)); // R11

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> (cpu_ready && !bus_req)); // R5

  AST_READY_IS_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready); // R5

endmodule

// File: tb/wu_snoop_cache_bench.sv
`timescale 1ns/1ps
module wu_snoop_cache_bench;
  localparam int AW = 8;
  localparam int IW = 2;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req;
  logic          bus_gnt = 1'b0;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_done = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic          snoop_valid;
  logic [AW-1:0] snoop_addr;
  logic [DW-1:0] snoop_wdata;

  // snoop sources: directed tasks and the memory model's collision injector
  logic          t_snp_v = 1'b0;
  logic [AW-1:0] t_snp_a = '0;
  logic [DW-1:0] t_snp_d = '0;
  logic          c_snp_v = 1'b0;
  logic [AW-1:0] c_snp_a = '0;
  logic [DW-1:0] c_snp_d = '0;

  assign snoop_valid = t_snp_v | c_snp_v;
  assign snoop_addr  = c_snp_v ? c_snp_a : t_snp_a;
  assign snoop_wdata = c_snp_v ? c_snp_d : t_snp_d;

  int checks = 0;
  int fails  = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int gnt_wait = 0;
  logic          coll_en = 1'b0;
  logic [AW-1:0] coll_a = '0;
  logic [DW-1:0] coll_d = '0;
  logic [AW-1:0] last_wa = '0;
  logic [DW-1:0] last_wd = '0;
  logic [DW-1:0] mem [256];

  always #2.5 clk = ~clk;

  wu_snoop_cache #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u_wu_snoop_cache (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_wdata(snoop_wdata)
  );

  task automatic check(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // memory and grant model
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'hA000 ^ 16'(i);
    forever begin
      @(negedge clk);
      bus_gnt  = 1'b0;
      bus_done = 1'b0;
      if (bus_req) begin
        repeat (gnt_wait) @(negedge clk);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt  = 1'b0;
        bus_done = 1'b1;
        if (coll_en) begin
          c_snp_v = 1'b1;
          c_snp_a = coll_a;
          c_snp_d = coll_d;
          mem[coll_a] = coll_d;
        end
        if (bus_we) begin
          mem[bus_addr] = bus_wdata;
          wr_cnt++;
          last_wa = bus_addr;
          last_wd = bus_wdata;
        end else begin
          bus_rdata = mem[bus_addr];
          rd_cnt++;
        end
        @(negedge clk);
        bus_done = 1'b0;
        c_snp_v  = 1'b0;
      end
    end
  end

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    lat = 1;
    while (!cpu_ready && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    rd = cpu_rdata;
  endtask

  task automatic snoop(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    t_snp_v = 1'b1; t_snp_a = a; t_snp_d = d;
    mem[a] = d;
    @(negedge clk);
    t_snp_v = 1'b0;
  endtask

  task automatic read_expect(input logic [AW-1:0] a, input logic [DW-1:0] exp_d,
                             input int exp_lat, input int exp_rd, input string tag);
    logic [DW-1:0] rd;
    int lat;
    int rd0;
    rd0 = rd_cnt;
    access(1'b0, a, '0, rd, lat);
    check(rd == exp_d, {tag, " read data"}, int'(rd), int'(exp_d));
    check(lat == exp_lat, {tag, " read latency"}, lat, exp_lat);
    check(rd_cnt - rd0 == exp_rd, {tag, " bus reads"}, rd_cnt - rd0, exp_rd);
  endtask

  task automatic write_expect(input logic [AW-1:0] a, input logic [DW-1:0] d,
                              input int exp_lat, input string tag);
    logic [DW-1:0] rd;
    int lat;
    int wr0;
    wr0 = wr_cnt;
    access(1'b1, a, d, rd, lat);
    check(wr_cnt - wr0 == 1, {tag, " bus write count"}, wr_cnt - wr0, 1);
    check(last_wa == a, {tag, " bus write addr"}, int'(last_wa), int'(a));
    check(last_wd == d, {tag, " bus write data"}, int'(last_wd), int'(d));
    check(lat == exp_lat, {tag, " write latency"}, lat, exp_lat);
  endtask

  task automatic t_reset();
    check(cpu_ready == 1'b0, "R1 ready low after reset", int'(cpu_ready), 0);
    check(bus_req == 1'b0, "R1 bus_req low after reset", int'(bus_req), 0);
    read_expect(8'h10, 16'hA010, 3, 1, "R1 first read misses / R5");
  endtask

  task automatic t_read_hit();
    int wr0;
    wr0 = wr_cnt;
    read_expect(8'h10, 16'hA010, 1, 0, "R6 read hit");
    check(wr_cnt == wr0, "R6 no bus write on hit", wr_cnt, wr0);
  endtask

  task automatic t_write_hit();
    write_expect(8'h10, 16'h1234, 3, "R2 write hit");
    read_expect(8'h10, 16'h1234, 1, 0, "R4 local copy updated");
  endtask

  task automatic t_write_miss();
    write_expect(8'h25, 16'hBEEF, 3, "R2 write miss");
    read_expect(8'h25, 16'hBEEF, 3, 1, "R3 no allocate on write miss");
  endtask

  task automatic t_snoop_hit();
    snoop(8'h10, 16'h5555);
    read_expect(8'h10, 16'h5555, 1, 0, "R7 snoop hit updates in place");
  endtask

  task automatic t_snoop_miss();
    snoop(8'h30, 16'h7777);
    read_expect(8'h10, 16'h5555, 1, 0, "R8 snoop other tag ignored");
    snoop(8'h22, 16'h6666);
    read_expect(8'h22, 16'h6666, 3, 1, "R8 snoop miss no allocate");
  endtask

  task automatic t_alias();
    read_expect(8'h30, 16'h7777, 3, 1, "R12 fill at shared index");
    read_expect(8'h10, 16'h5555, 3, 1, "R12 replaced line misses");
  endtask

  task automatic t_no_stall();
    logic [DW-1:0] rd;
    int lat;
    fork
      access(1'b0, 8'h10, '0, rd, lat);
      snoop(8'h25, 16'h2525);
    join
    check(lat == 1, "R9 hit latency with concurrent snoop", lat, 1);
    check(rd == 16'h5555, "R9 hit data with concurrent snoop", int'(rd), 16'h5555);
    read_expect(8'h25, 16'h2525, 1, 0, "R9 concurrent snoop kept");
  endtask

  task automatic t_grant_wait();
    gnt_wait = 5;
    write_expect(8'h10, 16'h4242, 8, "R11 grant withheld");
    gnt_wait = 0;
    read_expect(8'h10, 16'h4242, 1, 0, "R11 write landed after grant");
  endtask

  task automatic t_collision();
    coll_en = 1'b1; coll_a = 8'h10; coll_d = 16'h9999;
    write_expect(8'h10, 16'hABCD, 3, "R10 same entry");
    coll_en = 1'b0;
    read_expect(8'h10, 16'hABCD, 1, 0, "R10 processor wins same entry");
    coll_en = 1'b1; coll_a = 8'h25; coll_d = 16'h3131;
    write_expect(8'h10, 16'h0F0F, 3, "R10 different entries");
    coll_en = 1'b0;
    read_expect(8'h10, 16'h0F0F, 1, 0, "R10 processor entry");
    read_expect(8'h25, 16'h3131, 1, 0, "R10 snoop entry");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cpu_ready == 1'b0 && bus_req == 1'b0, "R1 quiet during reset", int'(bus_req), 0);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_hit();
    t_write_hit();
    t_write_miss();
    t_snoop_hit();
    t_snoop_miss();
    t_alias();
    t_no_stall();
    t_grant_wait();
    t_collision();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule